// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Seven-Segment Driver

This block drives a bank of common-anode seven-segment digits that share one set of segment lines. It lights one digit at a time and rotates through them. The scan is fast enough that the eye sees all digits lit at once. It takes a 16-bit value as four hexadecimal nibbles and a one-bit-per-digit decimal-point mask. It decodes the nibble of the digit being shown into its glyph, and drives active-low digit enables and active-low segment lines.

Everything runs on one 50 MHz system clock. The scan advance comes from a reloading down-counter that emits a one-cycle enable strobe, so no divided clock is used. With the default period of 200,000 cycles, each digit is shown for 4 ms and the full four-digit refresh runs at about 62.5 Hz. The reset input is an active-high push-button level; the block inverts it to an internal active-low reset that acts on the clock edge. The digit enable and the segment pattern come from one output register, so they always change on the same edge.

Top module: `seg_scan_driver`

## Requirements
- R1: A clock edge with `rst_btn` high drives every digit off (`an_n` all ones) and every segment off (`seg_n` = 8'hFF).
- R2: From the first clock edge after reset is released, exactly one bit of `an_n` is low at any time.
- R3: Digits are shown in the order 0, 1, 2, 3, 0, …, starting with digit 0 after reset. Digit d is enabled by `an_n[d]` low and shows nibble `value[4d+3:4d]`. Digit 0 is the rightmost digit and shows the least-significant nibble.
- R4: The scan strobe is one cycle wide and fires once every `SCAN_PERIOD` cycles. Each digit stays enabled for exactly `SCAN_PERIOD` cycles, except digit 0 right after reset, which is shown for one cycle.
- R5: A nibble n lights the segments of its hex glyph, given here active-high as {a,b,c,d,e,f,g}: 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B, A=77, b=1F, C=4E, d=3D, E=4F, F=47.
- R6: `seg_n` is active-low with bit order {a,b,c,d,e,f,g,dp} from bit 7 down to bit 0. `seg_n[0]` is the inverse of `dp_mask[d]` for the enabled digit d.
- R7: `an_n` and `seg_n` are registered from the same edge, using `value` and `dp_mask` as sampled at that edge. At a digit changeover, the new digit shows its own nibble from its first cycle. While the inputs are held, the outputs do not change within a digit's window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz |
| rst_btn | input | 1 | Active-high reset from a push button |
| value | input | 16 | Four hex nibbles; bits 3:0 go to digit 0 |
| dp_mask | input | 4 | Decimal-point request, one bit per digit |
| an_n | output | 4 | Active-low digit enables |
| seg_n | output | 8 | Active-low segments {a,b,c,d,e,f,g,dp} |

## Verification
Two things can happen in the same cycle: the registered changeover to the next digit, and a change of the displayed value. The bench rewrites `value` and `dp_mask` in the half-cycle before every changeover edge, with a different pattern in each window. It then expects the new digit to show the new nibble and decimal point from its first cycle, while the previous digit kept its old pattern up to its last cycle. A scoreboard compares every observed change of enable and segments against the queued prediction. It also measures how long each window lasts, so an early, late or stray output change is caught.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  localparam int NIB_W = 4;
  localparam int SEG_W = 8;

  // Active-high glyph, bit 6 = a ... bit 0 = g
  function automatic logic [6:0] hex_glyph(input logic [NIB_W-1:0] nib);
    logic [6:0] g;
    case (nib)
      4'h0: g = 7'h7E;
      4'h1: g = 7'h30;
      4'h2: g = 7'h6D;
      4'h3: g = 7'h79;
      4'h4: g = 7'h33;
      4'h5: g = 7'h5B;
      4'h6: g = 7'h5F;
      4'h7: g = 7'h70;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h7B;
      4'hA: g = 7'h77;
      4'hB: g = 7'h1F;
      4'hC: g = 7'h4E;
      4'hD: g = 7'h3D;
      4'hE: g = 7'h4F;
      default: g = 7'h47;
    endcase
    return g;
  endfunction

  // Active-low segment word {a..g, dp}
  function automatic logic [SEG_W-1:0] seg_word_n(input logic [NIB_W-1:0] nib,
                                                   input logic dp);
    return ~{hex_glyph(nib), dp};
  endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int PERIOD = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == '0)  cnt <= RELOAD;
    else                 cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);

  generate
    if (PERIOD > 1) begin : g_single
      // R4
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/digit_rotor.sv
module digit_rotor #(
  parameter int DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  output logic [$clog2(DIGITS)-1:0] idx
);
  localparam int IW = $clog2(DIGITS);
  localparam logic [IW-1:0] LAST = IW'(DIGITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (tick) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  // R3
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && idx == LAST) |=> idx == '0);
  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(idx));

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
  import seg_scan_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(DIGITS)-1:0] idx,
  input  logic [DIGITS*NIB_W-1:0]   value,
  input  logic [DIGITS-1:0]         dp_mask,
  output logic [DIGITS-1:0]         an_n,
  output logic [SEG_W-1:0]          seg_n
);
  logic [NIB_W-1:0]  cur_nib;
  logic              cur_dp;
  logic [DIGITS-1:0] cur_an_n;

  always_comb begin
    cur_nib  = value[idx*NIB_W +: NIB_W];
    cur_dp   = dp_mask[idx];
    cur_an_n = '1;
    cur_an_n[idx] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      an_n  <= '1;
      seg_n <= '1;
    end else begin
      an_n  <= cur_an_n;
      seg_n <= seg_word_n(cur_nib, cur_dp);
    end
  end

  // R1
  reset_dark_chk: assert property (@(posedge clk)
    !rst_n |=> (an_n == '1 && seg_n == '1));
  // R2
  single_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones(~an_n) == 1);

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
  import seg_scan_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int SCAN_PERIOD = 200000
) (
  input  logic                    clk,
  input  logic                    rst_btn,
  input  logic [DIGITS*NIB_W-1:0] value,
  input  logic [DIGITS-1:0]       dp_mask,
  output logic [DIGITS-1:0]       an_n,
  output logic [SEG_W-1:0]        seg_n
);
  localparam int IW = $clog2(DIGITS);
  localparam int GW = $clog2(SCAN_PERIOD + 1);

  logic          rst_n;
  logic          scan_tick;
  logic [IW-1:0] digit_idx;

  assign rst_n = ~rst_btn;

  scan_tick_gen #(.PERIOD(SCAN_PERIOD)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (scan_tick)
  );

  digit_rotor #(.DIGITS(DIGITS)) u_rotor (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (scan_tick),
    .idx   (digit_idx)
  );

  seg_out_stage #(.DIGITS(DIGITS)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx     (digit_idx),
    .value   (value),
    .dp_mask (dp_mask),
    .an_n    (an_n),
    .seg_n   (seg_n)
  );

  // Checker state: cycles since the last strobe, and which digit is lit
  logic [GW-1:0] gap;
  logic          seen_tick;
  logic [IW-1:0] lit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap       <= '0;
      seen_tick <= 1'b0;
    end else if (scan_tick) begin
      gap       <= '0;
      seen_tick <= 1'b1;
    end else begin
      gap       <= gap + 1'b1;
    end
  end

  always_comb begin
    lit_idx = '0;
    for (int i = 0; i < DIGITS; i++)
      if (!an_n[i]) lit_idx = IW'(i);
  end

  // R4
  tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && seen_tick) |-> gap == GW'(SCAN_PERIOD - 1));
  // R6
  dp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (an_n != '1) |-> (seg_n[0] == !(|(~an_n & $past(dp_mask)))));
  // R5
  glyph_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (an_n != '1) |->
      seg_n[7:1] == ~hex_glyph(NIB_W'($past(value) >> (NIB_W * lit_idx))));

endmodule

// File: tb/test_seg_scan_driver.sv
module test_seg_scan_driver;

  localparam int D = 4;
  localparam int P = 6;

  logic        clk = 1'b0;
  logic        rst_btn = 1'b1;
  logic [15:0] value = '0;
  logic [3:0]  dp_mask = '0;
  logic [3:0]  an_n;
  logic [7:0]  seg_n;

  always #10 clk = ~clk;

  seg_scan_driver #(.DIGITS(D), .SCAN_PERIOD(P)) i_seg_scan_driver (
    .clk     (clk),
    .rst_btn (rst_btn),
    .value   (value),
    .dp_mask (dp_mask),
    .an_n    (an_n),
    .seg_n   (seg_n)
  );

  typedef struct {
    logic [3:0] an;
    logic [7:0] seg;
    int         dwell;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 0;
  bit   have_prev = 0;
  bit   done = 0;
  int   run_len = 0;
  int   prev_dwell = 0;
  logic [11:0] last_obs;

  // Segments lit per nibble, listed a..g as active-high bits
  function automatic logic [6:0] ref_glyph(input logic [3:0] n);
    logic [6:0] t[16];
    t = '{7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001,
          7'b0110011, 7'b1011011, 7'b1011111, 7'b1110000,
          7'b1111111, 7'b1111011, 7'b1110111, 7'b0011111,
          7'b1001110, 7'b0111101, 7'b1001111, 7'b1000111};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per observed output change
  always @(negedge clk) begin
    #1;
    if (mon_on && an_n !== 4'hF) begin
      if (!have_prev || {an_n, seg_n} !== last_obs) begin
        if (have_prev && prev_dwell > 0)
          chk(run_len == prev_dwell, "R4", "window length", run_len, prev_dwell);
        chk($countones(~an_n) == 1, "R2", "enabled digits", an_n, 0);
        if (q.size() == 0) begin
          chk(1'b0, "R7", "unexpected output change", {an_n, seg_n}, 0);
          prev_dwell = 0;
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(an_n === e.an, "R3", "digit enable", an_n, e.an);
          chk(seg_n[7:1] === e.seg[7:1], "R5", "glyph", seg_n, e.seg);
          chk(seg_n[0] === e.seg[0], "R6", "decimal point", seg_n, e.seg);
          prev_dwell = e.dwell;
        end
        last_obs  = {an_n, seg_n};
        run_len   = 1;
        have_prev = 1;
      end else begin
        run_len++;
      end
    end
  end

  // Driver: resets, then changes the inputs right before every changeover edge
  task automatic run_scn(input logic [15:0] v, input logic [3:0] dpm, input int nwin);
    @(negedge clk);
    rst_btn = 1'b1;
    @(negedge clk);
    chk(an_n === 4'hF, "R1", "digits off in reset", an_n, 4'hF);
    chk(seg_n === 8'hFF, "R1", "segments off in reset", seg_n, 8'hFF);
    q.delete();
    have_prev = 0;
    mon_on = 1;
    rst_btn = 1'b0;
    for (int w = 0; w < nwin; w++) begin
      logic [15:0] vw;
      logic [3:0]  dw;
      int          d;
      exp_t        e;
      vw = v ^ (16'h1111 * 16'(w));
      dw = dpm ^ 4'(w);
      d  = w % D;
      value   = vw;
      dp_mask = dw;
      e.an    = ~(4'b0001 << d);
      e.seg   = ~{ref_glyph(vw[4*d +: 4]), dw[d]};
      e.dwell = (w == 0) ? 1 : P;
      q.push_back(e);
      if (w == 0) @(negedge clk);
      else repeat (P) @(negedge clk);
    end
    mon_on = 0;
    #2;
    chk(q.size() == 0, "R3", "windows left unseen", q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    run_scn(16'h0012, 4'b0000, 10);
    run_scn(16'h89AB, 4'b0101, 10);
    run_scn(16'hCDEF, 4'b1111, 9);
    run_scn(16'h3456, 4'b1000, 17);
    // reset while digits are lit (R1)
    @(negedge clk);
    rst_btn = 1'b1;
    @(negedge clk);
    chk(an_n === 4'hF, "R1", "digits off after late reset", an_n, 4'hF);
    chk(seg_n === 8'hFF, "R1", "segments off after late reset", seg_n, 8'hFF);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule